// File: doc/BRIEF.md
# OTU Row FEC Sub-Row Interleaver

This block sits in a byte-wide optical transport datapath. It accepts one byte per cycle from a frame of four rows of 4080 columns and keeps track of where that byte falls. Each row is treated as sixteen byte-interleaved codewords of 255 symbols. Every accepted byte comes out one cycle later with three tags: the codeword lane it belongs to, its symbol position inside that codeword, and its row number. A flag marks whether the byte is information or a parity slot.

Parity slots are the last 256 columns of a row, where each codeword holds symbols 240 to 255. In those slots the block replaces the incoming byte with a check byte. The check bytes arrive on a wide input that carries one byte per lane, and the block picks the byte of the current lane. Everywhere else the input byte passes through unchanged. The parity values themselves are computed outside the block from information symbols 1 to 239 of each lane. Frame alignment is also done outside. A frame-start pulse, qualified by valid, marks the first byte of row 1.

Top module: `otu_subrow_ilv`

## Requirements
- R1: After reset all outputs are zero, and the first valid byte, even without a frame-start pulse, is tagged row 1, lane 0, symbol 1.
- R2: A byte in column c (1..4080) is tagged lane (c-1) mod 16. Lane 0 holds columns 1, 17, 33 and so on.
- R3: A byte in column c is tagged symbol (c-1)/16 + 1, which lies in the range 1 to 255.
- R4: The info flag `out_info` is 1 for columns up to 3824 (symbols 1..239) and 0 for columns 3825..4080 (symbols 240..255).
- R5: In info columns `out_byte` equals the input byte of that cycle.
- R6: In parity columns `out_byte` equals bits [8*lane+7 : 8*lane] of `chk_lanes` in the cycle the byte was accepted.
- R7: The column wraps from 4080 back to 1, and the row then advances 1, 2, 3, 4, 1.
- R8: `in_sof` together with `in_valid` places that byte at row 1, column 1. `in_sof` while `in_valid` is low has no effect.
- R9: Each output appears one cycle after its byte is accepted, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low in the next cycle and does not advance the position.
- R10: Within a full row, every lane is tagged info exactly 239 times and parity exactly 16 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sof | input | 1 | Byte is row 1, column 1 of a frame (qualified by in_valid) |
| in_byte | input | 8 | Input stream byte |
| chk_lanes | input | 128 | One check byte per lane, lane i at bits [8i+7:8i] |
| out_valid | output | 1 | Output tags and byte are valid |
| out_byte | output | 8 | Merged stream byte |
| out_lane | output | 4 | Interleaved codeword lane, 0..15 |
| out_sym | output | 8 | Symbol index within the codeword, 1..255 |
| out_row | output | 3 | Row number, 1..4 |
| out_info | output | 1 | 1 for an information symbol, 0 for a parity slot |

## Verification
A whole frame is streamed after a frame-start pulse. A table of checkpoints at the edges of the info region, at lane wrap points and at row ends tells an off-by-one in the column-to-lane or column-to-symbol mapping apart from a wrong info/parity boundary. The input bytes depend on column and row, and the check bytes depend on lane and column, so a wrong pass-through or a wrong lane selection shows up as a data mismatch. Idle gaps, a frame-start pulse without valid, a mid-row frame start, and the wrap at the end of the frame separate faults in the position counter from faults in the mapping. Per-row counts of info and parity tags per lane confirm the 239/16 split.

// File: rtl/fec_ilv_pkg.sv
// Package: default geometry of the interleaved FEC row and small helpers.
// Assumes byte symbols and a row that is an exact multiple of the codeword count.
package fec_ilv_pkg;
    localparam int DEF_LANES    = 16;
    localparam int DEF_CODE_LEN = 255;
    localparam int DEF_INFO_LEN = 239;
    localparam int DEF_NUM_ROWS = 4;
    localparam int DEF_BYTE_W   = 8;

    // True when v is a power of two (lane index then comes from low column bits)
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/fec_ilv_pos_cnt.sv
// Module: zero-based row/column position of the byte currently offered.
// Assumes the frame-start pulse is qualified by valid; the position advances
// only on valid cycles and wraps at the end of the row and of the frame.
module fec_ilv_pos_cnt #(
    parameter int ROW_LEN  = 4080,
    parameter int NUM_ROWS = 4,
    parameter int COL_W    = 12,
    parameter int RIDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    output logic [COL_W-1:0]  cur_col0,
    output logic [RIDX_W-1:0] cur_row0
);
    logic [COL_W-1:0]  col0_q;
    logic [RIDX_W-1:0] row0_q;
    logic              sof_hit;

    // Position of this cycle's byte, with frame start forcing the origin
    always_comb begin
        sof_hit  = in_valid & in_sof;
        cur_col0 = sof_hit ? '0 : col0_q;
        cur_row0 = sof_hit ? '0 : row0_q;
    end

    // Advance past the accepted byte, wrapping column then row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col0_q <= '0;
            row0_q <= '0;
        end else if (in_valid) begin
            if (cur_col0 == COL_W'(ROW_LEN - 1)) begin
                col0_q <= '0;
                row0_q <= (cur_row0 == RIDX_W'(NUM_ROWS - 1)) ? '0 : cur_row0 + 1'b1;
            end else begin
                col0_q <= cur_col0 + 1'b1;
                row0_q <= cur_row0;
            end
        end
    end
endmodule

// File: rtl/fec_ilv_lane_map.sv
// Module: maps a zero-based column to codeword lane, symbol index and info flag.
// Assumes the columns are byte-interleaved across LANES codewords in order.
module fec_ilv_lane_map
    import fec_ilv_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int INFO_LEN = 239,
    parameter int COL_W    = 12,
    parameter int LANE_W   = 4,
    parameter int SYM_W    = 8
) (
    input  logic [COL_W-1:0]  col0,
    output logic [LANE_W-1:0] lane,
    output logic [SYM_W-1:0]  sym,
    output logic              info
);
    localparam int INFO_COLS = LANES * INFO_LEN;

    // Lane and symbol: bit slicing for a power-of-two lane count, else divide
    generate
        if (is_pow2(LANES)) begin : g_slice
            assign lane = col0[LANE_W-1:0];
            assign sym  = SYM_W'(col0 >> LANE_W) + SYM_W'(1);
        end else begin : g_divide
            assign lane = LANE_W'(col0 % COL_W'(LANES));
            assign sym  = SYM_W'(col0 / COL_W'(LANES)) + SYM_W'(1);
        end
    endgenerate

    // Info region ends where every lane has delivered its last info symbol
    assign info = (col0 < COL_W'(INFO_COLS));
endmodule

// File: rtl/fec_ilv_out_mux.sv
// Module: selects pass-through or the lane's check byte and registers all outputs.
// Assumes the check-byte bus is aligned with the byte offered in the same cycle.
module fec_ilv_out_mux #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    parameter int LANE_W = 4,
    parameter int SYM_W  = 8,
    parameter int ROW_W  = 3,
    parameter int RIDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BYTE_W-1:0]       in_byte,
    input  logic [LANES*BYTE_W-1:0] chk_lanes,
    input  logic [LANE_W-1:0]       lane,
    input  logic [SYM_W-1:0]        sym,
    input  logic                    info,
    input  logic [RIDX_W-1:0]       row0,
    output logic                    out_valid,
    output logic [BYTE_W-1:0]       out_byte,
    output logic [LANE_W-1:0]       out_lane,
    output logic [SYM_W-1:0]        out_sym,
    output logic [ROW_W-1:0]        out_row,
    output logic                    out_info
);
    logic [BYTE_W-1:0] merged;

    // Info bytes pass; parity slots take the current lane's check byte
    always_comb merged = info ? in_byte : chk_lanes[lane*BYTE_W +: BYTE_W];

    // One-cycle output stage, tags held between valid bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_lane  <= '0;
            out_sym   <= '0;
            out_row   <= '0;
            out_info  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_byte <= merged;
                out_lane <= lane;
                out_sym  <= sym;
                out_row  <= ROW_W'(row0) + ROW_W'(1);
                out_info <= info;
            end
        end
    end
endmodule

// File: rtl/otu_subrow_ilv.sv
// Module: top of the row FEC sub-row interleaver. It tags each streamed byte with
// lane, symbol and row, and merges external check bytes into the parity columns.
// Assumes one byte per valid cycle and an external frame-start pulse.
module otu_subrow_ilv
    import fec_ilv_pkg::*;
#(
    parameter int LANES    = DEF_LANES,
    parameter int CODE_LEN = DEF_CODE_LEN,
    parameter int INFO_LEN = DEF_INFO_LEN,
    parameter int NUM_ROWS = DEF_NUM_ROWS,
    parameter int BYTE_W   = DEF_BYTE_W,
    localparam int ROW_LEN = LANES * CODE_LEN,
    localparam int COL_W   = $clog2(ROW_LEN),
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SYM_W   = $clog2(CODE_LEN + 1),
    localparam int ROW_W   = $clog2(NUM_ROWS + 1),
    localparam int RIDX_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [BYTE_W-1:0]       in_byte,
    input  logic [LANES*BYTE_W-1:0] chk_lanes,
    output logic                    out_valid,
    output logic [BYTE_W-1:0]       out_byte,
    output logic [LANE_W-1:0]       out_lane,
    output logic [SYM_W-1:0]        out_sym,
    output logic [ROW_W-1:0]        out_row,
    output logic                    out_info
);
    logic [COL_W-1:0]  col0;
    logic [RIDX_W-1:0] row0;
    logic [LANE_W-1:0] lane;
    logic [SYM_W-1:0]  sym;
    logic              info;

    fec_ilv_pos_cnt #(
        .ROW_LEN(ROW_LEN), .NUM_ROWS(NUM_ROWS), .COL_W(COL_W), .RIDX_W(RIDX_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .cur_col0(col0), .cur_row0(row0)
    );

    fec_ilv_lane_map #(
        .LANES(LANES), .INFO_LEN(INFO_LEN), .COL_W(COL_W),
        .LANE_W(LANE_W), .SYM_W(SYM_W)
    ) u_map (
        .col0(col0), .lane(lane), .sym(sym), .info(info)
    );

    fec_ilv_out_mux #(
        .LANES(LANES), .BYTE_W(BYTE_W), .LANE_W(LANE_W),
        .SYM_W(SYM_W), .ROW_W(ROW_W), .RIDX_W(RIDX_W)
    ) u_mux (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .chk_lanes(chk_lanes), .lane(lane), .sym(sym), .info(info), .row0(row0),
        .out_valid(out_valid), .out_byte(out_byte), .out_lane(out_lane),
        .out_sym(out_sym), .out_row(out_row), .out_info(out_info)
    );
endmodule

// File: rtl/otu_subrow_ilv_chk.sv
// Module: checker for the interleaver's port behaviour, bound to the top.
// Assumes the default lane ordering and a one-cycle output stage.
module otu_subrow_ilv_chk #(
    parameter int LANES    = 16,
    parameter int CODE_LEN = 255,
    parameter int INFO_LEN = 239,
    parameter int NUM_ROWS = 4,
    parameter int BYTE_W   = 8,
    parameter int LANE_W   = 4,
    parameter int SYM_W    = 8,
    parameter int ROW_W    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sof,
    input logic [BYTE_W-1:0]       in_byte,
    input logic [LANES*BYTE_W-1:0] chk_lanes,
    input logic                    out_valid,
    input logic [BYTE_W-1:0]       out_byte,
    input logic [LANE_W-1:0]       out_lane,
    input logic [SYM_W-1:0]        out_sym,
    input logic [ROW_W-1:0]        out_row,
    input logic                    out_info
);
    // R9
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (out_valid && out_row == ROW_W'(1)
                                  && out_lane == '0 && out_sym == SYM_W'(1)));

    // R2
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && out_valid) |=>
        (out_lane == (($past(out_lane) == LANE_W'(LANES - 1)) ? '0
                                                              : $past(out_lane) + 1'b1)));

    // R3
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sym >= SYM_W'(1) && out_sym <= SYM_W'(CODE_LEN)
                       && out_row >= ROW_W'(1) && out_row <= ROW_W'(NUM_ROWS)));

    // R4
    info_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_info == (out_sym <= SYM_W'(INFO_LEN))));

    // R5
    pass_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_info) |-> (out_byte == $past(in_byte)));

    // R6
    check_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_info) |->
        (out_byte == BYTE_W'($past(chk_lanes) >> (out_lane * BYTE_W))));

    // R7
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && out_valid && out_lane == LANE_W'(LANES - 1)
         && out_sym == SYM_W'(CODE_LEN)) |=>
        (out_sym == SYM_W'(1) && out_row == (($past(out_row) == ROW_W'(NUM_ROWS))
                                             ? ROW_W'(1) : $past(out_row) + 1'b1)));
endmodule

bind otu_subrow_ilv otu_subrow_ilv_chk #(
    .LANES(LANES), .CODE_LEN(CODE_LEN), .INFO_LEN(INFO_LEN), .NUM_ROWS(NUM_ROWS),
    .BYTE_W(BYTE_W), .LANE_W(LANE_W), .SYM_W(SYM_W), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .chk_lanes(chk_lanes), .out_valid(out_valid),
    .out_byte(out_byte), .out_lane(out_lane), .out_sym(out_sym),
    .out_row(out_row), .out_info(out_info)
);

// File: tb/otu_subrow_ilv_bench.sv
`timescale 1ns/1ps
// Bench: streams bytes, models position independently, checks tags and data.
module otu_subrow_ilv_bench;
    localparam int LANES = 16, CODE_LEN = 255, INFO_LEN = 239, NUM_ROWS = 4;
    localparam int ROW_LEN = LANES * CODE_LEN;
    localparam int FRAME_LEN = ROW_LEN * NUM_ROWS;

    typedef struct packed {
        logic [2:0]  row;
        logic [11:0] col;
        logic [3:0]  lane;
        logic [7:0]  sym;
        logic        info;
    } cp_t;

    // Checkpoints: position in frame and hand-computed expected tags
    localparam cp_t CPTS [11] = '{
        '{3'd1, 12'd1,    4'd0,  8'd1,   1'b1},
        '{3'd1, 12'd16,   4'd15, 8'd1,   1'b1},
        '{3'd1, 12'd17,   4'd0,  8'd2,   1'b1},
        '{3'd1, 12'd3824, 4'd15, 8'd239, 1'b1},
        '{3'd1, 12'd3825, 4'd0,  8'd240, 1'b0},
        '{3'd1, 12'd4080, 4'd15, 8'd255, 1'b0},
        '{3'd2, 12'd1,    4'd0,  8'd1,   1'b1},
        '{3'd2, 12'd2000, 4'd15, 8'd125, 1'b1},
        '{3'd3, 12'd3840, 4'd15, 8'd240, 1'b0},
        '{3'd4, 12'd3841, 4'd0,  8'd241, 1'b0},
        '{3'd4, 12'd4080, 4'd15, 8'd255, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_sof;
    logic [7:0]   in_byte;
    logic [127:0] chk_lanes;
    logic         out_valid, out_info;
    logic [7:0]   out_byte, out_sym;
    logic [3:0]   out_lane;
    logic [2:0]   out_row;

    int vec_n = 0, miss_n = 0;
    int exp_row = 1, exp_col = 1, cp_idx = 0;
    int info_cnt [16];
    int par_cnt  [16];

    always #2.5 clk = ~clk;

    otu_subrow_ilv u_otu_subrow_ilv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .chk_lanes(chk_lanes), .out_valid(out_valid),
        .out_byte(out_byte), .out_lane(out_lane), .out_sym(out_sym),
        .out_row(out_row), .out_info(out_info)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vec_n++;
        if (!ok) begin
            miss_n++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < LANES; i++) begin
            info_cnt[i] = 0;
            par_cnt[i]  = 0;
        end
    endtask

    // Send one valid byte and check its tagged output one cycle later
    task automatic send(input logic sof);
        int e_lane, e_sym, e_data, e_chk;
        bit e_info;
        @(negedge clk);
        if (sof) begin
            exp_row = 1;
            exp_col = 1;
            clear_counts();
        end
        e_lane = (exp_col - 1) % LANES;
        e_sym  = (exp_col - 1) / LANES + 1;
        e_info = (exp_col <= LANES * INFO_LEN);
        e_data = (exp_col * 7 + exp_row * 13) & 255;
        e_chk  = ((8'hA0 ^ e_lane) + exp_col) & 255;
        in_valid = 1'b1;
        in_sof   = sof;
        in_byte  = 8'(e_data);
        for (int i = 0; i < LANES; i++)
            chk_lanes[i*8 +: 8] = 8'((8'hA0 ^ i) + exp_col);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        chk(out_valid == 1'b1, "R9 out_valid", int'(out_valid), 1);
        chk(out_row == exp_row, "R7 row", int'(out_row), exp_row);
        chk(out_lane == e_lane, "R2 lane", int'(out_lane), e_lane);
        chk(out_sym == e_sym, "R3 sym", int'(out_sym), e_sym);
        chk(out_info == e_info, "R4 info", int'(out_info), int'(e_info));
        if (e_info) chk(out_byte == e_data, "R5 pass byte", int'(out_byte), e_data);
        else        chk(out_byte == e_chk, "R6 check byte", int'(out_byte), e_chk);
        if (cp_idx < 11 && exp_row == int'(CPTS[cp_idx].row) && exp_col == int'(CPTS[cp_idx].col)) begin
            chk(out_lane == CPTS[cp_idx].lane, "R2 checkpoint lane", int'(out_lane), int'(CPTS[cp_idx].lane));
            chk(out_sym == CPTS[cp_idx].sym, "R3 checkpoint sym", int'(out_sym), int'(CPTS[cp_idx].sym));
            chk(out_info == CPTS[cp_idx].info, "R4 checkpoint info", int'(out_info), int'(CPTS[cp_idx].info));
            cp_idx++;
        end
        if (out_info) info_cnt[out_lane]++;
        else          par_cnt[out_lane]++;
        if (exp_col == ROW_LEN) begin
            for (int i = 0; i < LANES; i++) begin
                chk(info_cnt[i] == INFO_LEN, "R10 info count", info_cnt[i], INFO_LEN);
                chk(par_cnt[i] == CODE_LEN - INFO_LEN, "R10 parity count", par_cnt[i], CODE_LEN - INFO_LEN);
            end
            clear_counts();
            exp_col = 1;
            exp_row = (exp_row == NUM_ROWS) ? 1 : exp_row + 1;
        end else begin
            exp_col++;
        end
    endtask

    // One idle cycle, optionally with a stray frame-start pulse
    task automatic idle(input logic sof);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = sof;
        @(posedge clk);
        #1;
        in_sof = 1'b0;
        chk(out_valid == 1'b0, "R9 idle out_valid", int'(out_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        miss_n++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", vec_n, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_byte = '0; chk_lanes = '0;
        clear_counts();
        repeat (4) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_row == 3'd0, "R1 reset out_row", int'(out_row), 0);
        chk(out_sym == 8'd0, "R1 reset out_sym", int'(out_sym), 0);
        chk(out_byte == 8'd0 && out_lane == 4'd0, "R1 reset data/lane", int'(out_byte), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first bytes without a frame start begin at row 1, column 1
        for (int k = 0; k < 5; k++) send(1'b0);
        // R8: frame start with valid low is ignored, position continues at column 6
        idle(1'b1);
        send(1'b0);
        // R8: mid-row frame start, then a whole frame with idle gaps (R9)
        send(1'b1);
        for (int k = 1; k < FRAME_LEN; k++) begin
            if (k % 997 == 0) idle(1'b0);
            send(1'b0);
        end
        chk(cp_idx == 11, "R2 checkpoints reached", cp_idx, 11);
        // R7: frame wraps back to row 1, column 1 without a new frame start
        for (int k = 0; k < 3; k++) send(1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end
endmodule